// File: doc/BRIEF.md
# Sliding Backplane Window Mapper

This block sits between a requester that thinks in terms of cores on a 32-bit backplane and a narrow access port that only reaches a 17-bit function address space. The lower 64 KB of that space is a movable view onto the backplane. The upper half holds control registers. Three of those registers set where the view points. A request names a core index, a 16-bit offset inside that core, an access width (8, 16 or 32 bits) and a direction. The block turns it into one or more accesses on the downstream port.

The block keeps a private copy of the window base it last programmed. When a request targets a different base, the window is moved first with three byte writes. The data access then follows. When the base already matches, only the data access is issued. An optional quirk mode follows every 32-bit write with a throw-away 32-bit read of address zero. Every downstream completion that reports an error raises a one-cycle error flag. A failed window move aborts the request and returns all-ones data.

Top module: `winmap_top`

## Requirements
- R1: After reset the block is idle, with `busy`, `dnValid`, `respValid` and `errPulse` low. The cached base starts at all ones, so the first request always moves the window.
- R2: A window move is three 8-bit writes (size code 0), issued strictly in this order. The first goes to 0x1000A with target bits [15:8] ANDed with 0x80. The second goes to 0x1000B with bits [23:16]. The third goes to 0x1000C with bits [31:24]. Each byte sits in `dnWdata[7:0]` with the upper bits zero.
- R3: The target base is `ENUM_BASE + core * CORE_SIZE`, which defaults to 0x18000000 + core * 0x1000.
- R4: A request whose target base equals the cached base issues no window writes.
- R5: The data access uses address bit 16 = 0. Its low 16 bits are (offset OR cached base[15:0]) AND 0x7FFF. It carries the request's size code (0 = 8, 1 = 16, 2 = 32 bit), direction and write data.
- R6: A 32-bit data access additionally sets address bit 15.
- R7: If any window write reports an error, the data access is skipped and the cached base is left unchanged, so the next request to that core moves the window again. The response data is all ones for the width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R8: With `quirkEn` high, every 32-bit write is followed by a 32-bit read of address 0, whose data is discarded. Reads, 8/16-bit writes, and writes with `quirkEn` low get no extra access.
- R9: `errPulse` is high for exactly the cycle after each downstream completion that has `dnErr` set.
- R10: `respValid` is high for one cycle, the cycle after the last downstream completion of the request. Read data is zero-extended from the access width. A successful write returns zero.
- R11: `reqValid` is only taken while `busy` is low. A request presented while busy causes no access and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| quirkEn | input | 1 | Add dummy read after 32-bit writes |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqCore | input | CORE_W | Target core index |
| reqOffset | input | 16 | Offset inside the core |
| reqSize | input | 2 | Width code: 0 = 8, 1 = 16, 2 = 32 bit |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | A request is in progress |
| respValid | output | 1 | One-cycle response strobe |
| respData | output | 32 | Read data or all-ones on window failure |
| dnValid | output | 1 | Downstream access pending |
| dnAddr | output | 17 | Function-space address |
| dnSize | output | 2 | Downstream width code |
| dnWrite | output | 1 | Downstream direction |
| dnWdata | output | 32 | Downstream write data |
| dnDone | input | 1 | Downstream completion, with dnValid |
| dnErr | input | 1 | Completion carried an error |
| dnRdata | input | 32 | Downstream read data, valid with dnDone |
| errPulse | output | 1 | One-cycle flag per failed completion |

## Verification
The first downstream access appears the cycle after the request is taken. Each later access appears the cycle after the previous completion. `respValid` and `errPulse` both land in the cycle after the final completion. The bench completes accesses and samples all outputs on the falling edge, with a variable completion latency. Each access is compared when it is completed against a queue that the behavioural model filled in order. Responses and error pulses are counted per request and compared once the response has arrived, so a missing, extra or late item shows up as a count mismatch.

// File: rtl/winmap_pkg.sv
package winmap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WLO,
    PH_WMID,
    PH_WHI,
    PH_DATA,
    PH_DUMMY,
    PH_RESP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   commitBase;
    logic   latchData;
    logic   markFail;
    phase_t phase;
  } ctrlStrobe_t;

  localparam int FN_ADDR_W = 17;
  localparam int OFS_W     = 16;

  localparam logic [FN_ADDR_W-1:0] WIN_LO_ADDR  = 17'h1000A;
  localparam logic [FN_ADDR_W-1:0] WIN_MID_ADDR = 17'h1000B;
  localparam logic [FN_ADDR_W-1:0] WIN_HI_ADDR  = 17'h1000C;

  localparam logic [7:0] WIN_LO_MASK  = 8'h80;
  localparam logic [7:0] WIN_MID_MASK = 8'hFF;
  localparam logic [7:0] WIN_HI_MASK  = 8'hFF;

  localparam logic [OFS_W-1:0] OFS_KEEP_MASK = 16'h7FFF;
  localparam int               OFS_WIDE_BIT  = 15;

  function automatic logic [31:0] fitWidth(accSize_t sz, logic [31:0] v);
    case (sz)
      SZ_BYTE: return {24'h0, v[7:0]};
      SZ_HALF: return {16'h0, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/winmap_ctrl.sv
module winmap_ctrl
  import winmap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hitNow,
  input  logic        wideWrite,
  input  logic        quirkEn,
  input  logic        dnDone,
  input  logic        dnErr,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        dnValid,
  output logic        respValid,
  output logic        errPulse
);

  phase_t state, nextState;

  always_comb begin
    strobe       = '0;
    strobe.phase = state;
    nextState    = state;
    case (state)
      PH_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = hitNow ? PH_DATA : PH_WLO;
        end
      end
      PH_WLO: begin
        if (dnDone) begin
          if (dnErr) begin
            strobe.markFail = 1'b1;
            nextState       = PH_RESP;
          end else begin
            nextState = PH_WMID;
          end
        end
      end
      PH_WMID: begin
        if (dnDone) begin
          if (dnErr) begin
            strobe.markFail = 1'b1;
            nextState       = PH_RESP;
          end else begin
            nextState = PH_WHI;
          end
        end
      end
      PH_WHI: begin
        if (dnDone) begin
          if (dnErr) begin
            strobe.markFail = 1'b1;
            nextState       = PH_RESP;
          end else begin
            strobe.commitBase = 1'b1;
            nextState         = PH_DATA;
          end
        end
      end
      PH_DATA: begin
        if (dnDone) begin
          strobe.latchData = 1'b1;
          nextState        = (quirkEn && wideWrite) ? PH_DUMMY : PH_RESP;
        end
      end
      PH_DUMMY: begin
        if (dnDone) nextState = PH_RESP;
      end
      PH_RESP:  nextState = PH_IDLE;
      default:  nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      errPulse <= 1'b0;
    end else begin
      state    <= nextState;
      errPulse <= dnValid && dnDone && dnErr;
    end
  end

  always_comb begin
    busy      = (state != PH_IDLE);
    respValid = (state == PH_RESP);
    dnValid   = (state == PH_WLO) || (state == PH_WMID) || (state == PH_WHI) ||
                (state == PH_DATA) || (state == PH_DUMMY);
  end

endmodule

// File: rtl/winmap_datapath.sv
module winmap_datapath
  import winmap_pkg::*;
#(
  parameter int          CORE_W    = 8,
  parameter int          CORE_SIZE = 4096,
  parameter logic [31:0] ENUM_BASE = 32'h1800_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [OFS_W-1:0]     reqOffset,
  input  logic [1:0]           reqSize,
  input  logic                 reqWrite,
  input  logic [31:0]          reqWdata,
  input  logic [31:0]          dnRdata,
  output logic                 hitNow,
  output logic                 wideWrite,
  output logic [FN_ADDR_W-1:0] dnAddr,
  output logic [1:0]           dnSize,
  output logic                 dnWrite,
  output logic [31:0]          dnWdata,
  output logic [31:0]          respData
);

  localparam int          CORE_SHIFT  = $clog2(CORE_SIZE);
  localparam bit          SIZE_POW2   = ((CORE_SIZE & (CORE_SIZE - 1)) == 0);
  localparam logic [31:0] CORE_SIZE_L = 32'(CORE_SIZE);

  logic [31:0]      coreExt, targetNow;
  logic [31:0]      cacheBase, targetQ, wdataQ, rdataQ;
  logic [OFS_W-1:0] offsetQ, dataOfs;
  accSize_t         sizeQ;
  logic             writeQ, failQ;

  assign coreExt = 32'(reqCore);

  generate
    if (SIZE_POW2) begin : g_shiftBase
      assign targetNow = ENUM_BASE + (coreExt << CORE_SHIFT);
    end else begin : g_mulBase
      assign targetNow = ENUM_BASE + coreExt * CORE_SIZE_L;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheBase <= '1;
      targetQ   <= '0;
      offsetQ   <= '0;
      sizeQ     <= SZ_BYTE;
      writeQ    <= 1'b0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      failQ     <= 1'b0;
    end else begin
      if (strobe.capture) begin
        targetQ <= targetNow;
        offsetQ <= reqOffset;
        sizeQ   <= accSize_t'(reqSize);
        writeQ  <= reqWrite;
        wdataQ  <= reqWdata;
        failQ   <= 1'b0;
      end
      if (strobe.commitBase) cacheBase <= targetQ;
      if (strobe.latchData)  rdataQ    <= dnRdata;
      if (strobe.markFail)   failQ     <= 1'b1;
    end
  end

  assign hitNow    = (targetNow == cacheBase);
  assign wideWrite = writeQ && (sizeQ == SZ_WORD);

  always_comb begin
    dataOfs = (offsetQ | cacheBase[OFS_W-1:0]) & OFS_KEEP_MASK;
    if (sizeQ == SZ_WORD) dataOfs[OFS_WIDE_BIT] = 1'b1;
  end

  always_comb begin
    dnAddr  = '0;
    dnSize  = SZ_BYTE;
    dnWrite = 1'b0;
    dnWdata = '0;
    case (strobe.phase)
      PH_WLO: begin
        dnAddr  = WIN_LO_ADDR;
        dnWrite = 1'b1;
        dnWdata = {24'h0, targetQ[15:8] & WIN_LO_MASK};
      end
      PH_WMID: begin
        dnAddr  = WIN_MID_ADDR;
        dnWrite = 1'b1;
        dnWdata = {24'h0, targetQ[23:16] & WIN_MID_MASK};
      end
      PH_WHI: begin
        dnAddr  = WIN_HI_ADDR;
        dnWrite = 1'b1;
        dnWdata = {24'h0, targetQ[31:24] & WIN_HI_MASK};
      end
      PH_DATA: begin
        dnAddr  = {1'b0, dataOfs};
        dnSize  = sizeQ;
        dnWrite = writeQ;
        dnWdata = wdataQ;
      end
      PH_DUMMY: begin
        dnAddr = '0;
        dnSize = SZ_WORD;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (failQ)       respData = fitWidth(sizeQ, 32'hFFFF_FFFF);
    else if (writeQ) respData = '0;
    else             respData = fitWidth(sizeQ, rdataQ);
  end

endmodule

// File: rtl/winmap_top.sv
module winmap_top
  import winmap_pkg::*;
#(
  parameter int          CORE_W    = 8,
  parameter int          CORE_SIZE = 4096,
  parameter logic [31:0] ENUM_BASE = 32'h1800_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 quirkEn,
  input  logic                 reqValid,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [15:0]          reqOffset,
  input  logic [1:0]           reqSize,
  input  logic                 reqWrite,
  input  logic [31:0]          reqWdata,
  output logic                 busy,
  output logic                 respValid,
  output logic [31:0]          respData,
  output logic                 dnValid,
  output logic [16:0]          dnAddr,
  output logic [1:0]           dnSize,
  output logic                 dnWrite,
  output logic [31:0]          dnWdata,
  input  logic                 dnDone,
  input  logic                 dnErr,
  input  logic [31:0]          dnRdata,
  output logic                 errPulse
);

  ctrlStrobe_t strobe;
  logic        hitNow, wideWrite;

  winmap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .hitNow    (hitNow),
    .wideWrite (wideWrite),
    .quirkEn   (quirkEn),
    .dnDone    (dnDone),
    .dnErr     (dnErr),
    .strobe    (strobe),
    .busy      (busy),
    .dnValid   (dnValid),
    .respValid (respValid),
    .errPulse  (errPulse)
  );

  winmap_datapath #(
    .CORE_W    (CORE_W),
    .CORE_SIZE (CORE_SIZE),
    .ENUM_BASE (ENUM_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqCore   (reqCore),
    .reqOffset (reqOffset),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .dnRdata   (dnRdata),
    .hitNow    (hitNow),
    .wideWrite (wideWrite),
    .dnAddr    (dnAddr),
    .dnSize    (dnSize),
    .dnWrite   (dnWrite),
    .dnWdata   (dnWdata),
    .respData  (respData)
  );

endmodule

// File: rtl/winmap_chk.sv
module winmap_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        dnValid,
  input logic        dnDone,
  input logic        dnErr,
  input logic [16:0] dnAddr,
  input logic [1:0]  dnSize,
  input logic        dnWrite,
  input logic        respValid,
  input logic        errPulse
);

  // R2
  win_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnDone && !dnErr && dnAddr == 17'h1000A) |=> (dnValid && dnAddr == 17'h1000B));

  // R2
  win_byte_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnAddr[16]) |-> (dnWrite && dnSize == 2'd0));

  // R6
  wide_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnAddr[16] && dnSize == 2'd2 && dnAddr != 17'h0) |-> dnAddr[15]);

  // R7
  win_fail_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnDone && dnErr && dnAddr[16]) |=> (!dnValid && respValid));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnDone && dnErr) |=> errPulse);

  // R10
  resp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && !busy));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dnValid);

endmodule

bind winmap_top winmap_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .dnValid   (dnValid),
  .dnDone    (dnDone),
  .dnErr     (dnErr),
  .dnAddr    (dnAddr),
  .dnSize    (dnSize),
  .dnWrite   (dnWrite),
  .respValid (respValid),
  .errPulse  (errPulse)
);

// File: tb/winmap_top_test.sv
module winmap_top_test;

  localparam int          CW = 8;
  localparam logic [31:0] EB = 32'h1800_0000;
  localparam logic [31:0] CS = 32'h0000_1000;

  logic        clk, rstN, quirkEn, reqValid, reqWrite;
  logic [CW-1:0] reqCore;
  logic [15:0] reqOffset;
  logic [1:0]  reqSize;
  logic [31:0] reqWdata;
  logic        busy, respValid, dnValid, dnWrite, dnDone, dnErr, errPulse;
  logic [31:0] respData, dnWdata, dnRdata;
  logic [16:0] dnAddr;
  logic [1:0]  dnSize;

  winmap_top #(.CORE_W(CW), .CORE_SIZE(4096), .ENUM_BASE(EB)) uut (
    .clk(clk), .rstN(rstN), .quirkEn(quirkEn), .reqValid(reqValid),
    .reqCore(reqCore), .reqOffset(reqOffset), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .busy(busy),
    .respValid(respValid), .respData(respData), .dnValid(dnValid),
    .dnAddr(dnAddr), .dnSize(dnSize), .dnWrite(dnWrite), .dnWdata(dnWdata),
    .dnDone(dnDone), .dnErr(dnErr), .dnRdata(dnRdata), .errPulse(errPulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [16:0] addr;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        err;
    logic [31:0] rd;
  } acc_t;

  acc_t        expQ[$];
  int          nChk = 0, nBad = 0, lat = 0, waitCnt = 0, errSeen = 0, respSeen = 0;
  string       curTag = "R1";
  logic [31:0] respGot = '0;
  logic [31:0] mCache;
  bit          finished = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fitW(logic [1:0] sz, logic [31:0] v);
    if (sz == 2'd0) return {24'h0, v[7:0]};
    if (sz == 2'd1) return {16'h0, v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] rdFor(logic [16:0] a);
    return 32'hA1B2_C3D4 ^ {15'h0, a};
  endfunction

  // downstream responder and output monitor, all on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (errPulse) errSeen++;
      if (respValid) begin
        respSeen++;
        respGot = respData;
      end
    end
    if (!rstN) begin
      dnDone = 0; dnErr = 0; dnRdata = '0; waitCnt = 0;
    end else if (dnDone) begin
      dnDone = 0; dnErr = 0; waitCnt = 0;
    end else if (dnValid) begin
      if (waitCnt < lat) waitCnt++;
      else if (expQ.size() == 0) begin
        check(0, curTag, "unexpected downstream access at", {15'h0, dnAddr}, 32'h0);
        dnDone = 1; dnErr = 0;
      end else begin
        acc_t e;
        e = expQ.pop_front();
        check(dnAddr == e.addr, curTag, "access address", {15'h0, dnAddr}, {15'h0, e.addr});
        check(dnWrite == e.wr, curTag, "access direction", {31'h0, dnWrite}, {31'h0, e.wr});
        check(dnSize == e.sz, curTag, "access size", {30'h0, dnSize}, {30'h0, e.sz});
        if (e.wr) check(dnWdata == e.wd, curTag, "write data", dnWdata, e.wd);
        dnErr = e.err; dnRdata = e.rd; dnDone = 1;
      end
    end
  end

  task automatic pushAcc(logic [16:0] a, logic w, logic [1:0] s, logic [31:0] d, logic e, logic [31:0] r);
    acc_t x;
    x.addr = a; x.wr = w; x.sz = s; x.wd = d; x.err = e; x.rd = r;
    expQ.push_back(x);
  endtask

  // errs: [0] low window write, [1] mid, [2] high, [3] data access, [4] dummy read
  task automatic run(logic [CW-1:0] core, logic [15:0] ofs, logic [1:0] sz, logic wr,
                     logic [31:0] wd, logic [4:0] errs, string tag, bit poke);
    logic [31:0] tgt, expResp, rd;
    logic [15:0] o;
    bit          fail;
    int          expErr;
    curTag = tag; fail = 0; expErr = 0; rd = '0;
    tgt = EB + 32'(core) * CS;
    if (tgt != mCache) begin
      pushAcc(17'h1000A, 1, 2'd0, {24'h0, tgt[15:8] & 8'h80}, errs[0], '0);
      if (errs[0]) begin fail = 1; expErr++; end
      if (!fail) begin
        pushAcc(17'h1000B, 1, 2'd0, {24'h0, tgt[23:16]}, errs[1], '0);
        if (errs[1]) begin fail = 1; expErr++; end
      end
      if (!fail) begin
        pushAcc(17'h1000C, 1, 2'd0, {24'h0, tgt[31:24]}, errs[2], '0);
        if (errs[2]) begin fail = 1; expErr++; end
      end
      if (!fail) mCache = tgt;
    end
    if (!fail) begin
      o = (ofs | mCache[15:0]) & 16'h7FFF;
      if (sz == 2'd2) o[15] = 1'b1;
      rd = rdFor({1'b0, o});
      pushAcc({1'b0, o}, wr, sz, wd, errs[3], rd);
      if (errs[3]) expErr++;
      if (quirkEn && wr && sz == 2'd2) begin
        pushAcc(17'h0, 0, 2'd2, '0, errs[4], 32'h5555_AAAA);
        if (errs[4]) expErr++;
      end
    end
    expResp = fail ? fitW(sz, 32'hFFFF_FFFF) : (wr ? 32'h0 : fitW(sz, rd));

    errSeen = 0; respSeen = 0;
    reqCore = core; reqOffset = ofs; reqSize = sz; reqWrite = wr; reqWdata = wd;
    reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    if (poke) begin
      check(busy == 1'b1, tag, "busy during request", {31'h0, busy}, 32'h1);
      reqCore = core + 8'd1; reqOffset = 16'h0BAD; reqWrite = 1;
      reqValid = 1;
      @(negedge clk);
      reqValid = 0;
    end
    for (int i = 0; i < 400 && respSeen == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(respSeen == 1, "R10", "response count", respSeen, 1);
    check(respGot == expResp, tag, "response data", respGot, expResp);
    check(errSeen == expErr, "R9", "error pulse count", errSeen, expErr);
    check(expQ.size() == 0, tag, "expected accesses left over", expQ.size(), 0);
    check(busy == 1'b0 && dnValid == 1'b0, tag, "idle after response", {30'h0, busy, dnValid}, 32'h0);
    expQ = {};
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; quirkEn = 0; reqValid = 0; reqCore = '0; reqOffset = '0;
    reqSize = '0; reqWrite = 0; reqWdata = '0; dnDone = 0; dnErr = 0; dnRdata = '0;
    mCache = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check({busy, dnValid, respValid, errPulse} == 4'b0, "R1", "outputs after reset",
          {28'h0, busy, dnValid, respValid, errPulse}, 32'h0);

    // R1 R3 R6: first request moves window, 32-bit read
    run(8'd3, 16'h0124, 2'd2, 0, 32'h0, 5'b0, "R1 R3 R6", 0);
    // R4 R5: same core, no window writes, 16-bit read
    run(8'd3, 16'h0042, 2'd1, 0, 32'h0, 5'b0, "R4 R5", 0);
    lat = 1;
    // R2 R5: low window byte mask, offset masking, 8-bit write
    run(8'h0B, 16'hFFFF, 2'd0, 1, 32'h0000_005C, 5'b0, "R2 R5", 0);
    // R2 R3 R8: mid byte, 32-bit write without quirk gets no dummy read
    run(8'h80, 16'h0010, 2'd2, 1, 32'hDEAD_BEEF, 5'b0, "R2 R3 R8", 0);
    lat = 0;
    // R7: window failures at each stage, all-ones by width
    run(8'd5, 16'h0002, 2'd1, 0, 32'h0, 5'b00010, "R7", 0);
    run(8'd5, 16'h0001, 2'd0, 0, 32'h0, 5'b00001, "R7", 0);
    run(8'd5, 16'h0100, 2'd2, 0, 32'h0, 5'b00100, "R7", 0);
    // R7: cache unchanged, so the window is moved again
    run(8'd5, 16'h0100, 2'd2, 0, 32'h0, 5'b0, "R7", 0);
    // R9: data access error still returns data and pulses once
    run(8'd5, 16'h0200, 2'd2, 0, 32'h0, 5'b01000, "R9", 0);
    quirkEn = 1;
    // R8: quirk adds dummy read after 32-bit write only
    run(8'd5, 16'h0300, 2'd2, 1, 32'h0123_4567, 5'b0, "R8", 0);
    run(8'd5, 16'h0302, 2'd1, 1, 32'h0000_BEEF, 5'b0, "R8", 0);
    run(8'd5, 16'h0304, 2'd2, 0, 32'h0, 5'b0, "R8", 0);
    lat = 1;
    run(8'd7, 16'h0004, 2'd2, 1, 32'hCAFE_F00D, 5'b10000, "R8 R9", 0);
    quirkEn = 0;
    lat = 2;
    // R11: request presented while busy is ignored
    run(8'd9, 16'h0008, 2'd2, 0, 32'h0, 5'b0, "R11", 1);
    lat = 0;
    // R4: cache hit after the ignored request
    run(8'd9, 16'h000C, 2'd0, 0, 32'h0, 5'b0, "R4", 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule